// File: doc/BRIEF.md
# FIFO-Buffered Configuration Port Controller

This block sits between a processor register bus and a device configuration port. Both directions carry 32-bit words. Software pushes configuration words into a deep write FIFO and sets a start bit. The controller then streams those words out on a valid/ready output stream until the FIFO is empty. Software may push more words and set the start bit again while a transfer is running, and the transfer carries on with the new words.

For readback, software loads a word count into a size register and sets a read start bit. The controller accepts exactly that many words from a valid/ready input stream into a read FIFO, which software then pops through a register. The controller takes a port word only while the read FIFO has room, so no word is lost.

A status word reports completion, four constant one bits and four status flags from the port. Software can also read the free space of the write FIFO and the fill level of the read FIFO. Two control bits act as one-shot commands: one empties both FIFOs, and one resets the whole block. Bus reads return data one cycle after the request.

Top module: `cfgport_ctrl`

## Requirements
- R1: After reset, the status register (0x110) reads 0x1F with all port flags low, write vacancy (0x114) reads 1024, read occupancy (0x118) reads 0, size (0x108) reads 0 and control (0x10C) reads 0. A bus read returns its data on the cycle after the request.
- R2: A bus write to 0x100 pushes the data word into the 1024-word write FIFO and lowers the vacancy by one. A write while the FIFO is full is dropped silently: vacancy stays 0 and that word is never sent.
- R3: Writing control bit 0 starts draining the write FIFO onto the output stream in push order. A word is offered with out_valid and held stable until out_ready. While draining, status bit 0 (done) is 0 and control bit 0 reads 1. Both return to done=1 and bit 0 = 0 once the FIFO is empty.
- R4: Words pushed while a transfer runs, with control bit 0 written again, are sent after the earlier words, and the transfer ends only when all of them have gone out.
- R5: A write to 0x108 stores the readback count, clamped to 0xFFF, so writing 0x1234 reads back 0xFFF. Writing control bit 1 makes the controller accept exactly that many words from the input stream. During that time done is 0 and control bit 1 reads 1.
- R6: A bus read of 0x104 pops the oldest read FIFO word. A read when the FIFO is empty returns 0 and changes nothing. Occupancy (0x118) gives the filled word count.
- R7: Status bit 0 is done, bits 4..1 always read 1, and bits 8..5 mirror port_flags[3:0], with flag bit 0 at status bit 5. All other bits read 0.
- R8: Writing control bit 2 empties both FIFOs: vacancy returns to 1024 and occupancy to 0. The size register keeps its value.
- R9: Writing control bit 3 returns every register to its reset value, flushes both FIFOs and stops both transfers, so no flushed word is sent afterwards.
- R10: When the 256-word read FIFO is full, in_ready stays low and port words wait. Readback continues once software pops words, with no word lost or reordered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| cfg_out_valid | output | 1 | Output stream word valid |
| cfg_out_ready | input | 1 | Port accepts the output word |
| cfg_out_data | output | 32 | Output stream word |
| cfg_in_valid | input | 1 | Port offers a readback word |
| cfg_in_ready | output | 1 | Controller accepts the readback word |
| cfg_in_data | input | 32 | Readback word |
| port_flags | input | 4 | Port status flags shown in status bits 8..5 |

## Verification
The output stream is tested with three ready patterns: held low, always high and toggling each cycle. Held low shows that words wait with stable data. Always high shows order and the point at which done returns. Toggling, together with a second start mid-transfer, shows that appended words join the running transfer. Readback uses a count larger than the read FIFO, so the FIFO fills and stalls the port before software drains it. This separates correct back-pressure from lost or reordered words. Overflow, empty pops, size clamping, FIFO clear with its kept size value, and soft reset during a stalled transfer each have their own scenario.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    // Register byte offsets; software decodes these
    localparam logic [ADDR_W-1:0] OFS_WFIFO  = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_RFIFO  = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_SIZE   = 12'h108;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h10C;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h110;
    localparam logic [ADDR_W-1:0] OFS_VACANT = 12'h114;
    localparam logic [ADDR_W-1:0] OFS_FILLED = 12'h118;

    // One-shot commands carried by a control write, bit 3 down to bit 0
    typedef struct packed {
        logic soft_rst;
        logic fifo_clr;
        logic rd_start;
        logic wr_start;
    } ctrl_cmd_t;

    function automatic ctrl_cmd_t decode_ctrl(input logic [3:0] bits);
        ctrl_cmd_t c;
        c.soft_rst = bits[3];
        c.fifo_clr = bits[2];
        c.rd_start = bits[1];
        c.wr_start = bits[0];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input logic done,
                                                      input logic [3:0] flags);
        return {{(DATA_W-9){1'b0}}, flags, 4'hF, done};
    endfunction

endpackage

// File: rtl/cfg_fifo.sv
module cfg_fifo #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // R2: the fill level never exceeds the depth
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R6: popping an empty FIFO leaves it empty
    a_r6_empty_pop_noop: assert property (@(posedge clk) disable iff (rst)
        empty && pop && !push |=> empty);

endmodule

// File: rtl/cfg_wr_engine.sv
module cfg_wr_engine #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             start,
    input  logic             push_now,
    input  logic             fifo_empty,
    input  logic [WIDTH-1:0] fifo_dout,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    output logic             pop,
    output logic             busy
);

    assign out_valid = busy && !fifo_empty;
    assign out_data  = fifo_dout;
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
        end else if (start) begin
            busy <= 1'b1;
        end else if (busy && fifo_empty && !push_now) begin
            busy <= 1'b0;
        end
    end

    // R3: an offered word waits, unchanged, until the port takes it
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready && !clr |=> out_valid && $stable(out_data));

    // R3: a transfer ends only with an empty write FIFO
    a_r3_end_when_drained: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> fifo_empty);

endmodule

// File: rtl/cfg_rd_engine.sv
module cfg_rd_engine #(
    parameter int SZW = 12
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [SZW-1:0] size,
    input  logic           in_valid,
    input  logic           fifo_full,
    output logic           in_ready,
    output logic           push,
    output logic           busy
);

    logic [SZW-1:0] remaining;

    assign busy     = (remaining != '0);
    assign in_ready = busy && !fifo_full;
    assign push     = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
        end else if (start) begin
            remaining <= size;
        end else if (push) begin
            remaining <= remaining - 1'b1;
        end
    end

    // R5: without a new request the outstanding count never grows
    a_r5_count_down: assert property (@(posedge clk) disable iff (rst)
        !start |=> remaining <= $past(remaining));

    // R10: no word is accepted into a full read FIFO
    a_r10_no_push_full: assert property (@(posedge clk) disable iff (rst)
        fifo_full |-> !push);

endmodule

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
    import cfgport_pkg::*;
#(
    parameter int WR_DEPTH = 1024,
    parameter int RD_DEPTH = 256,
    parameter int MAX_RD   = 4095
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cfg_out_valid,
    input  logic              cfg_out_ready,
    output logic [DATA_W-1:0] cfg_out_data,
    input  logic              cfg_in_valid,
    output logic              cfg_in_ready,
    input  logic [DATA_W-1:0] cfg_in_data,
    input  logic [3:0]        port_flags
);

    localparam int WCW = $clog2(WR_DEPTH + 1);
    localparam int RCW = $clog2(RD_DEPTH + 1);
    localparam int SZW = $clog2(MAX_RD + 1);

    ctrl_cmd_t         cmd;
    logic              rst_all, clr;
    logic              wr_push, wr_pop, wr_full, wr_empty, wr_busy;
    logic [DATA_W-1:0] wr_dout;
    logic [WCW-1:0]    wr_count;
    logic              rd_push, rd_pop, rd_full, rd_empty, rd_busy;
    logic [DATA_W-1:0] rd_dout;
    logic [RCW-1:0]    rd_count;
    logic [SZW-1:0]    size_q;
    logic [DATA_W-1:0] rdata_d;
    logic              done;

    // Bus decode
    assign cmd     = (bus_wr && bus_addr == OFS_CTRL) ? decode_ctrl(bus_wdata[3:0]) : '0;
    assign rst_all = rst || cmd.soft_rst;
    assign clr     = cmd.fifo_clr;
    assign wr_push = bus_wr && (bus_addr == OFS_WFIFO);
    assign rd_pop  = bus_rd && (bus_addr == OFS_RFIFO) && !rd_empty;
    assign done    = !wr_busy && !rd_busy;

    // Readback size register with clamping
    always_ff @(posedge clk) begin
        if (rst_all) begin
            size_q <= '0;
        end else if (bus_wr && bus_addr == OFS_SIZE) begin
            if (bus_wdata > DATA_W'(MAX_RD)) size_q <= SZW'(MAX_RD);
            else                             size_q <= SZW'(bus_wdata);
        end
    end

    cfg_fifo #(.DEPTH(WR_DEPTH), .WIDTH(DATA_W)) u_wfifo (
        .clk   (clk),
        .rst   (rst_all),
        .clr   (clr),
        .push  (wr_push),
        .din   (bus_wdata),
        .pop   (wr_pop),
        .dout  (wr_dout),
        .count (wr_count),
        .full  (wr_full),
        .empty (wr_empty)
    );

    cfg_fifo #(.DEPTH(RD_DEPTH), .WIDTH(DATA_W)) u_rfifo (
        .clk   (clk),
        .rst   (rst_all),
        .clr   (clr),
        .push  (rd_push),
        .din   (cfg_in_data),
        .pop   (rd_pop),
        .dout  (rd_dout),
        .count (rd_count),
        .full  (rd_full),
        .empty (rd_empty)
    );

    cfg_wr_engine #(.WIDTH(DATA_W)) u_wr_eng (
        .clk        (clk),
        .rst        (rst_all),
        .clr        (clr),
        .start      (cmd.wr_start),
        .push_now   (wr_push),
        .fifo_empty (wr_empty),
        .fifo_dout  (wr_dout),
        .out_ready  (cfg_out_ready),
        .out_valid  (cfg_out_valid),
        .out_data   (cfg_out_data),
        .pop        (wr_pop),
        .busy       (wr_busy)
    );

    cfg_rd_engine #(.SZW(SZW)) u_rd_eng (
        .clk       (clk),
        .rst       (rst_all),
        .start     (cmd.rd_start),
        .size      (size_q),
        .in_valid  (cfg_in_valid),
        .fifo_full (rd_full),
        .in_ready  (cfg_in_ready),
        .push      (rd_push),
        .busy      (rd_busy)
    );

    // Read data mux, registered
    always_comb begin
        rdata_d = '0;
        case (bus_addr)
            OFS_RFIFO:  rdata_d = rd_empty ? '0 : rd_dout;
            OFS_SIZE:   rdata_d = DATA_W'(size_q);
            OFS_CTRL:   rdata_d = {{(DATA_W-2){1'b0}}, rd_busy, wr_busy};
            OFS_STATUS: rdata_d = status_word(done, port_flags);
            OFS_VACANT: rdata_d = DATA_W'(WR_DEPTH) - DATA_W'(wr_count);
            OFS_FILLED: rdata_d = DATA_W'(rd_count);
            default:    rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst_all)     bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rdata_d;
    end

    // R6: a pop of the empty read FIFO returns zero
    a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (rst_all)
        bus_rd && bus_addr == OFS_RFIFO && rd_empty |=> bus_rdata == '0);

    // R7: the constant status bits read as ones
    a_r7_fixed_ones: assert property (@(posedge clk) disable iff (rst_all)
        bus_rd && bus_addr == OFS_STATUS |=> bus_rdata[4:1] == 4'hF);

    // R2: a push into a full FIFO that nobody drains leaves it full
    a_r2_full_drop: assert property (@(posedge clk) disable iff (rst_all)
        wr_full && wr_push && !wr_pop && !clr |=> wr_full);

    // R9: soft reset clears size and both FIFOs
    a_r9_soft_reset: assert property (@(posedge clk) disable iff (rst)
        cmd.soft_rst |=> size_q == '0 && wr_count == '0 && rd_count == '0);

    // R8: FIFO clear keeps the size register
    a_r8_clear_keeps_size: assert property (@(posedge clk) disable iff (rst_all)
        clr && !(bus_wr && bus_addr == OFS_SIZE) |=> $stable(size_q));

endmodule

// File: tb/cfgport_ctrl_bench.sv
module cfgport_ctrl_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cfg_out_valid, cfg_in_ready;
    logic [31:0] cfg_out_data;
    logic        cfg_out_ready;
    logic        cfg_in_valid = 1'b0;
    logic [31:0] cfg_in_data;
    logic [3:0]  port_flags = 4'h0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int rmode = 0;
    logic tog = 1'b0;
    int sink_n = 0;
    logic [31:0] sink_mem [2048];
    int src_n = 0;

    always #(CLK_P/2) clk = ~clk;

    always @(negedge clk) tog <= ~tog;
    assign cfg_out_ready = (rmode == 1) || (rmode == 2 && tog);
    assign cfg_in_data   = 32'hA000_0000 + 32'(src_n);

    always @(posedge clk) begin
        if (cfg_out_valid && cfg_out_ready) begin
            if (sink_n < 2048) sink_mem[sink_n] <= cfg_out_data;
            sink_n <= sink_n + 1;
        end
        if (cfg_in_valid && cfg_in_ready) src_n <= src_n + 1;
    end

    cfgport_ctrl u_cfgport_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cfg_out_valid(cfg_out_valid), .cfg_out_ready(cfg_out_ready),
        .cfg_out_data(cfg_out_data), .cfg_in_valid(cfg_in_valid),
        .cfg_in_ready(cfg_in_ready), .cfg_in_data(cfg_in_data),
        .port_flags(port_flags)
    );

    localparam logic [11:0] A_WF = 12'h100, A_RF = 12'h104, A_SZ = 12'h108,
                            A_CR = 12'h10C, A_SR = 12'h110, A_VC = 12'h114,
                            A_OC = 12'h118;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bwr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] d;
        brd(a, d);
        chk(req, d, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        rd_chk("R1 status", A_SR, 32'h1F);
        rd_chk("R1 vacancy", A_VC, 32'd1024);
        rd_chk("R1 occupancy", A_OC, 32'd0);
        rd_chk("R1 size", A_SZ, 32'd0);
        rd_chk("R1 control", A_CR, 32'd0);
    endtask

    task automatic t_flags;
        port_flags = 4'b1010;
        rd_chk("R7 flags mirror", A_SR, 32'h15F);
        port_flags = 4'b0001;
        rd_chk("R7 flag0 at bit5", A_SR, 32'h3F);
        port_flags = 4'b0000;
    endtask

    task automatic t_drain;
        int base = sink_n;
        int bad = 0;
        rmode = 0;
        for (int i = 0; i < 5; i++) bwr(A_WF, 32'h1000 + 32'(i));
        rd_chk("R2 vacancy after push", A_VC, 32'd1019);
        bwr(A_CR, 32'h1);
        rd_chk("R3 busy status", A_SR, 32'h1E);
        rd_chk("R3 control bit0 set", A_CR, 32'h1);
        wait_cyc(5);
        chk("R3 held without ready", 32'(sink_n - base), 32'd0);
        rmode = 1;
        wait_cyc(10);
        chk("R3 words sent", 32'(sink_n - base), 32'd5);
        for (int i = 0; i < 5; i++)
            if (sink_mem[base + i] !== 32'h1000 + 32'(i)) bad++;
        chk("R3 word order", 32'(bad), 32'd0);
        rd_chk("R3 done after drain", A_SR, 32'h1F);
        rd_chk("R3 control self-clear", A_CR, 32'h0);
    endtask

    task automatic t_append;
        int base = sink_n;
        int bad = 0;
        rmode = 2;
        for (int i = 0; i < 3; i++) bwr(A_WF, 32'h2000 + 32'(i));
        bwr(A_CR, 32'h1);
        for (int i = 3; i < 6; i++) bwr(A_WF, 32'h2000 + 32'(i));
        bwr(A_CR, 32'h1);
        wait_cyc(20);
        chk("R4 all words sent", 32'(sink_n - base), 32'd6);
        for (int i = 0; i < 6; i++)
            if (sink_mem[base + i] !== 32'h2000 + 32'(i)) bad++;
        chk("R4 appended order", 32'(bad), 32'd0);
        rd_chk("R4 done", A_SR, 32'h1F);
    endtask

    task automatic t_overflow;
        int base = sink_n;
        int bad = 0;
        rmode = 0;
        for (int i = 0; i < 1025; i++) bwr(A_WF, 32'h5000 + 32'(i));
        rd_chk("R2 vacancy full", A_VC, 32'd0);
        rmode = 1;
        bwr(A_CR, 32'h1);
        wait_cyc(1040);
        chk("R2 dropped word not sent", 32'(sink_n - base), 32'd1024);
        for (int i = 0; i < 1024; i++)
            if (sink_mem[base + i] !== 32'h5000 + 32'(i)) bad++;
        chk("R2 kept words intact", 32'(bad), 32'd0);
        rd_chk("R2 vacancy restored", A_VC, 32'd1024);
    endtask

    task automatic t_readback;
        logic [31:0] d;
        int bad = 0;
        int base = src_n;
        bwr(A_SZ, 32'h1234);
        rd_chk("R5 size clamp", A_SZ, 32'hFFF);
        bwr(A_SZ, 32'd300);
        rd_chk("R5 size value", A_SZ, 32'd300);
        cfg_in_valid = 1'b1;
        bwr(A_CR, 32'h2);
        rd_chk("R5 control bit1 set", A_CR, 32'h2);
        rd_chk("R5 busy status", A_SR, 32'h1E);
        wait_cyc(300);
        rd_chk("R10 occupancy full", A_OC, 32'd256);
        chk("R10 port stalled", 32'(src_n - base), 32'd256);
        for (int i = 0; i < 300; i++) begin
            brd(A_RF, d);
            if (d !== 32'hA000_0000 + 32'(base + i)) bad++;
        end
        chk("R10 no loss or reorder", 32'(bad), 32'd0);
        wait_cyc(3);
        chk("R5 exact word count", 32'(src_n - base), 32'd300);
        rd_chk("R5 done", A_SR, 32'h1F);
        rd_chk("R6 empty read zero", A_RF, 32'd0);
        rd_chk("R6 occupancy zero", A_OC, 32'd0);
        cfg_in_valid = 1'b0;
    endtask

    task automatic t_clear;
        rmode = 0;
        bwr(A_SZ, 32'd3);
        cfg_in_valid = 1'b1;
        bwr(A_CR, 32'h2);
        wait_cyc(8);
        cfg_in_valid = 1'b0;
        rd_chk("R6 occupancy count", A_OC, 32'd3);
        for (int i = 0; i < 4; i++) bwr(A_WF, 32'h7000 + 32'(i));
        rd_chk("R8 vacancy before", A_VC, 32'd1020);
        bwr(A_CR, 32'h4);
        rd_chk("R8 vacancy cleared", A_VC, 32'd1024);
        rd_chk("R8 occupancy cleared", A_OC, 32'd0);
        rd_chk("R8 size kept", A_SZ, 32'd3);
        rd_chk("R8 read after clear", A_RF, 32'd0);
    endtask

    task automatic t_soft_reset;
        int base;
        rmode = 0;
        bwr(A_SZ, 32'd7);
        bwr(A_WF, 32'h9000);
        bwr(A_WF, 32'h9001);
        bwr(A_CR, 32'h1);
        rd_chk("R9 busy before", A_SR, 32'h1E);
        bwr(A_CR, 32'h8);
        rd_chk("R9 status default", A_SR, 32'h1F);
        rd_chk("R9 control default", A_CR, 32'h0);
        rd_chk("R9 size default", A_SZ, 32'h0);
        rd_chk("R9 vacancy default", A_VC, 32'd1024);
        base = sink_n;
        rmode = 1;
        wait_cyc(5);
        chk("R9 flushed words not sent", 32'(sink_n - base), 32'd0);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R3 actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(3);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_flags();
        t_drain();
        t_append();
        t_overflow();
        t_readback();
        t_clear();
        t_soft_reset();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule